// File: doc/BRIEF.md
# Interrupt Frame Sequencer with Tail-Chained Handler Entry

This block runs the stack traffic around interrupt handlers for a small processor core. It keeps a set of latched request lines. When it is idle and any line is pending, it saves an eight-word register frame below the stack pointer through a memory port that moves one word per cycle. It then reads the handler address for the chosen line from a vector table, loads that address into the program counter, and holds the core in handler mode until the core reports that the handler has returned.

At handler return the sequencer does one of two things. If no request is waiting, it reads the frame back into the register file through a restore port, moves the stack pointer back up, and goes idle so the interrupted code resumes. If a request was already latched when the return pulse arrives, it skips both the restore and the next save. It goes straight to the vector fetch for the waiting line and reuses the frame that is already on the stack. A status output tells which of the two entry paths led to the current handler.

The frame order on the memory port is fixed: word k sits at frame base + 4·k. The register-file index k means r0, r1, r2, r3, r12, r14, r15 and status for k = 0 to 7.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and in the first idle cycles after it, mem_req_o, mem_we_o, pc_load_o, reg_wr_o, sp_wr_o, handler_run_o and chain_o are all 0.
- R2: When idle with any line latched, the next 8 cycles each issue one write with mem_we_o=1 to address (sp_i − 32) + 4·k for k = 0..7, with reg_rd_idx_o = k and mem_wdata_o equal to reg_rd_data_i. In the cycle with k = 7, sp_wr_o=1 and sp_wr_data_o = sp_i − 32.
- R3: In the cycle after the last save word there is one read (mem_we_o=0) at vec_base_i + 4·n. In that same cycle pc_load_o=1 and pc_load_data_o equals mem_rdata_i. From the next cycle handler_run_o=1.
- R4: A pulse on irq_i stays latched until its line is vectored, and the vectored line's bit is cleared in the fetch cycle. A pulse that arrives during the save neither shortens nor changes it.
- R5: A handler return with no line latched gives 8 reads at sp_i + 4·k. Each read drives reg_wr_o=1, reg_wr_idx_o = k and reg_wr_data_o = mem_rdata_i. In the cycle with k = 7, sp_wr_data_o = sp_i + 32. Next comes an idle cycle, and the stack pointer is back at its value before entry.
- R6: A handler return while a line is already latched is followed in the very next cycle by the vector fetch, with no write, restore or stack pointer update in between. The frame from the first entry is still the one restored at the final return.
- R7: chain_o is 1 while a handler runs that was entered through the tail chain, and 0 while a handler runs that was entered after a save.
- R8: A request that arrives in the same cycle as the handler return, or during the restore, does not cut the restore short. All 8 reads complete, one idle cycle follows, and then a full 8-word save.
- R9: From the return cycle to the PC load, the chained path takes 1 cycle and the restore-then-save path takes 18, so the chained path saves at least 8 cycles.
- R10: When several lines are latched at a vector fetch, the lowest-numbered one is chosen (n in R3).
- R11: handler_done_i has no effect while handler_run_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_IRQ | Request pulses, one per line |
| handler_done_i | input | 1 | Pulse: the running handler has returned |
| sp_i | input | XLEN | Current stack pointer |
| vec_base_i | input | XLEN | Vector table base address |
| reg_rd_idx_o | output | log2(FRAME_WORDS) | Frame slot selected on the register read port |
| reg_rd_data_i | input | XLEN | Register value for reg_rd_idx_o |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | XLEN | Byte address of the word |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, valid in the cycle of the request |
| reg_wr_o | output | 1 | Restore one frame slot |
| reg_wr_idx_o | output | log2(FRAME_WORDS) | Slot being restored |
| reg_wr_data_o | output | XLEN | Restore value |
| sp_wr_o | output | 1 | Load new stack pointer |
| sp_wr_data_o | output | XLEN | New stack pointer value |
| pc_load_o | output | 1 | Load program counter |
| pc_load_data_o | output | XLEN | Handler address |
| handler_run_o | output | 1 | Core is executing a handler |
| chain_o | output | 1 | Current handler was entered by tail chain |

## Verification
Two events can fall in the same cycle: a new request and the handler-return pulse. The bench drives irq_i and handler_done_i on the same clock edge. The sequencer must then take the full restore path rather than the chain: 8 restores, an idle cycle, 8 saves and only then the fetch, with chain_o at 0. The bench also drives the request one cycle before the return, which must give the one-cycle chained fetch. Requests that land during the save are a second pairing, and the bench checks that the save keeps its 8 words and that the fetch picks the lowest latched line.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PUSH = 3'd1,
      ST_VEC  = 3'd2,
      ST_RUN  = 3'd3,
      ST_POP  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/irq_seq_pend.sv
module irq_seq_pend #(
   parameter int NUM_IRQ = 8,
   parameter int IDW     = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] req_i,
   input  logic               clr_i,
   input  logic [IDW-1:0]     clr_idx_i,
   output logic               any_o,
   output logic [IDW-1:0]     sel_o
);
   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] clr_mask;
   logic [NUM_IRQ-1:0] grant;
   logic [NUM_IRQ:0]   seen;

   assign clr_mask = clr_i ? (NUM_IRQ'(1) << clr_idx_i) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_mask) | req_i;
   end

   // lowest index wins: each line is masked by every line below it
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
      assign grant[i]  = pend_q[i] & ~seen[i];
      assign seen[i+1] = seen[i] | pend_q[i];
   end

   always_comb begin
      sel_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (grant[i]) sel_o = IDW'(i);
      end
   end

   assign any_o = seen[NUM_IRQ];

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !req_i[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]); // R4
   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4
endmodule

// File: rtl/irq_seq_walk.sv
module irq_seq_walk #(
   parameter int FRAME_WORDS = 8,
   parameter int CW          = $clog2(FRAME_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o
);
   logic [CW-1:0] cnt_q;

   assign last_o = run_i && (cnt_q == CW'(FRAME_WORDS - 1));
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i || last_o) cnt_q <= '0;
      else                            cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int XLEN        = 32,
   parameter int FRAME_WORDS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_IRQ-1:0]             irq_i,
   input  logic                           handler_done_i,
   input  logic [XLEN-1:0]                sp_i,
   input  logic [XLEN-1:0]                vec_base_i,
   output logic [$clog2(FRAME_WORDS)-1:0] reg_rd_idx_o,
   input  logic [XLEN-1:0]                reg_rd_data_i,
   output logic                           mem_req_o,
   output logic                           mem_we_o,
   output logic [XLEN-1:0]                mem_addr_o,
   output logic [XLEN-1:0]                mem_wdata_o,
   input  logic [XLEN-1:0]                mem_rdata_i,
   output logic                           reg_wr_o,
   output logic [$clog2(FRAME_WORDS)-1:0] reg_wr_idx_o,
   output logic [XLEN-1:0]                reg_wr_data_o,
   output logic                           sp_wr_o,
   output logic [XLEN-1:0]                sp_wr_data_o,
   output logic                           pc_load_o,
   output logic [XLEN-1:0]                pc_load_data_o,
   output logic                           handler_run_o,
   output logic                           chain_o
);
   localparam int IDW         = $clog2(NUM_IRQ);
   localparam int CW          = $clog2(FRAME_WORDS);
   localparam int BYTES       = XLEN / 8;
   localparam int SHIFT       = $clog2(BYTES);
   localparam int FRAME_BYTES = FRAME_WORDS * BYTES;

   if (NUM_IRQ < 2) begin : g_bad_irq
      $error("NUM_IRQ must be at least 2");
   end
   if ((XLEN % 8) != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_xlen
      $error("XLEN must be a power-of-two number of bytes");
   end
   if (FRAME_WORDS < 2) begin : g_bad_frame
      $error("FRAME_WORDS must be at least 2");
   end

   seq_state_e     state_q, state_d;
   logic [XLEN-1:0] base_q, base_d;
   logic            chain_q, chain_d;
   logic            pend_any;
   logic [IDW-1:0]  sel;
   logic [CW-1:0]   cnt;
   logic            last;
   logic            walking;
   logic            ret_ev;

   assign walking = (state_q == ST_PUSH) || (state_q == ST_POP);
   assign ret_ev  = (state_q == ST_RUN) && handler_done_i;

   irq_seq_pend #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (irq_i),
      .clr_i    (state_q == ST_VEC),
      .clr_idx_i(sel),
      .any_o    (pend_any),
      .sel_o    (sel)
   );

   irq_seq_walk #(.FRAME_WORDS(FRAME_WORDS), .CW(CW)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (walking),
      .cnt_o (cnt),
      .last_o(last)
   );

   always_comb begin
      state_d = state_q;
      base_d  = base_q;
      chain_d = chain_q;
      unique case (state_q)
         ST_IDLE: if (pend_any) begin
            state_d = ST_PUSH;
            base_d  = sp_i - XLEN'(FRAME_BYTES);
         end
         ST_PUSH: if (last) begin
            state_d = ST_VEC;
            chain_d = 1'b0;
         end
         ST_VEC:  state_d = ST_RUN;
         ST_RUN: if (handler_done_i) begin
            if (pend_any) begin
               state_d = ST_VEC;
               chain_d = 1'b1;
            end else begin
               state_d = ST_POP;
               base_d  = sp_i;
            end
         end
         ST_POP:  if (last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         chain_q <= 1'b0;
      end else begin
         state_q <= state_d;
         base_q  <= base_d;
         chain_q <= chain_d;
      end
   end

   assign reg_rd_idx_o   = cnt;
   assign mem_req_o      = walking || (state_q == ST_VEC);
   assign mem_we_o       = (state_q == ST_PUSH);
   assign mem_addr_o     = (state_q == ST_VEC)
                           ? vec_base_i + (XLEN'(sel) << SHIFT)
                           : base_q + (XLEN'(cnt) << SHIFT);
   assign mem_wdata_o    = reg_rd_data_i;
   assign reg_wr_o       = (state_q == ST_POP);
   assign reg_wr_idx_o   = cnt;
   assign reg_wr_data_o  = mem_rdata_i;
   assign sp_wr_o        = last;
   assign sp_wr_data_o   = (state_q == ST_PUSH) ? base_q : base_q + XLEN'(FRAME_BYTES);
   assign pc_load_o      = (state_q == ST_VEC);
   assign pc_load_data_o = mem_rdata_i;
   assign handler_run_o  = (state_q == ST_RUN);
   assign chain_o        = chain_q;

   AST_SAVE_RESTORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && reg_wr_o)); // R2
   AST_SAVE_SP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && sp_wr_o) |-> (sp_wr_data_o == mem_addr_o - XLEN'(FRAME_BYTES - BYTES))); // R2
   AST_SAVE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && sp_wr_o) |=> (pc_load_o && mem_req_o && !mem_we_o)); // R3
   AST_RESTORE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o && sp_wr_o) |=> (!mem_req_o && !handler_run_o)); // R5
   AST_CHAIN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_ev && pend_any) |=> (pc_load_o && !mem_we_o && !reg_wr_o && !sp_wr_o)); // R6
   AST_CHAIN_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && $past(handler_run_o)) |=> chain_o); // R7
   AST_CHAIN_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && $past(mem_we_o)) |=> !chain_o); // R7
   AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (handler_done_i && !handler_run_o && !mem_req_o && !pend_any) |=> !mem_req_o); // R11
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   localparam int NI = 8;
   localparam logic [31:0] VT  = 32'h0000_0040;
   localparam logic [31:0] SP0 = 32'h0000_03C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NI-1:0] irq_i = '0;
   logic        handler_done_i = 1'b0;
   logic [31:0] sp;
   logic [2:0]  reg_rd_idx_o;
   logic [31:0] reg_rd_data_i;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        reg_wr_o;
   logic [2:0]  reg_wr_idx_o;
   logic [31:0] reg_wr_data_o;
   logic        sp_wr_o;
   logic [31:0] sp_wr_data_o;
   logic        pc_load_o;
   logic [31:0] pc_load_data_o;
   logic        handler_run_o, chain_o;

   logic [31:0] mem [256];
   logic [31:0] rf [8];
   logic [31:0] saved [8];
   logic [NI-1:0] pend_b;
   int total = 0;
   int bad = 0;
   int cyc = 0;
   int t_done = 0;
   int chain_gap = -1;
   int full_gap = -1;

   always #5 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .handler_done_i(handler_done_i),
      .sp_i(sp), .vec_base_i(VT), .reg_rd_idx_o(reg_rd_idx_o), .reg_rd_data_i(reg_rd_data_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .reg_wr_o(reg_wr_o),
      .reg_wr_idx_o(reg_wr_idx_o), .reg_wr_data_o(reg_wr_data_o), .sp_wr_o(sp_wr_o),
      .sp_wr_data_o(sp_wr_data_o), .pc_load_o(pc_load_o), .pc_load_data_o(pc_load_data_o),
      .handler_run_o(handler_run_o), .chain_o(chain_o)
   );

   assign mem_rdata_i   = mem[mem_addr_o[9:2]];
   assign reg_rd_data_i = rf[reg_rd_idx_o];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req_o && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      if (reg_wr_o) rf[reg_wr_idx_o] <= reg_wr_data_o;
      if (sp_wr_o) sp <= sp_wr_data_o;
   end

   function automatic logic [31:0] vec_val(input int n);
      return 32'h0000_1000 + 32'(n) * 32'h10;
   endfunction

   function automatic int lowest(input logic [NI-1:0] m);
      for (int i = NI - 1; i >= 0; i--) if (m[i]) lowest = i;
      if (m == '0) lowest = -1;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic quiet(input string req);
      chk(!mem_req_o && !pc_load_o && !handler_run_o && !reg_wr_o && !sp_wr_o, req,
          {27'd0, mem_req_o, pc_load_o, handler_run_o, reg_wr_o, sp_wr_o}, 32'd0);
   endtask

   // pulse lines for one cycle; afterwards the sequencer sits in its idle cycle
   task automatic pulse(input logic [NI-1:0] m);
      irq_i = m;
      tick;
      irq_i = '0;
      pend_b |= m;
   endtask

   task automatic do_push(input logic [NI-1:0] inj, input int inj_k);
      logic [31:0] base;
      base = sp - 32'd32;
      for (int k = 0; k < 8; k++) begin
         irq_i = (k == inj_k) ? inj : '0;
         chk(mem_req_o && mem_we_o, "R2 save write", {31'd0, mem_we_o}, 32'd1);
         chk(mem_addr_o == base + 32'(4 * k), "R2 save address", mem_addr_o, base + 32'(4 * k));
         chk(mem_wdata_o == rf[k], "R2 save data", mem_wdata_o, rf[k]);
         if (k == 7) chk(sp_wr_o && sp_wr_data_o == base, "R2 sp after save", sp_wr_data_o, base);
         else        chk(!sp_wr_o, "R4 save not shortened", {31'd0, sp_wr_o}, 32'd0);
         tick;
      end
      irq_i = '0;
      if (inj_k >= 0) pend_b |= inj;
   endtask

   task automatic do_vec(input bit exp_chain);
      int n;
      n = lowest(pend_b);
      chk(mem_req_o && !mem_we_o && pc_load_o, "R3 fetch cycle", {30'd0, mem_we_o, pc_load_o}, 32'd1);
      chk(mem_addr_o == VT + 32'(4 * n), "R10 lowest line vectored", mem_addr_o, VT + 32'(4 * n));
      chk(pc_load_data_o == vec_val(n), "R3 pc load value", pc_load_data_o, vec_val(n));
      if (exp_chain) chain_gap = cyc - t_done;
      pend_b[n] = 1'b0;
      tick;
      chk(handler_run_o, "R3 handler running", {31'd0, handler_run_o}, 32'd1);
      chk(chain_o == exp_chain, "R7 chain flag", {31'd0, chain_o}, {31'd0, exp_chain});
   endtask

   task automatic do_pop;
      logic [31:0] base;
      base = sp;
      for (int k = 0; k < 8; k++) begin
         chk(mem_req_o && !mem_we_o && reg_wr_o, "R5 restore read", {30'd0, mem_we_o, reg_wr_o}, 32'd1);
         chk(mem_addr_o == base + 32'(4 * k), "R5 restore address", mem_addr_o, base + 32'(4 * k));
         chk(reg_wr_idx_o == 3'(k) && reg_wr_data_o == saved[k], "R6 frame intact",
             reg_wr_data_o, saved[k]);
         if (k == 7) chk(sp_wr_o && sp_wr_data_o == base + 32'd32, "R5 sp after restore",
                         sp_wr_data_o, base + 32'd32);
         tick;
      end
      quiet("R8 idle cycle after restore");
   endtask

   // run handler for len cycles, optional request mid-handler and at the return edge
   task automatic handler(input int len, input logic [NI-1:0] extra, input logic [NI-1:0] coinc);
      for (int i = 0; i < len; i++) begin
         chk(handler_run_o && !mem_req_o, "R3 handler holds", {31'd0, handler_run_o}, 32'd1);
         irq_i = (i == 0) ? extra : '0;
         if ($urandom_range(0, 1) == 1) rf[$urandom_range(0, 7)] = $urandom;
         tick;
      end
      pend_b |= extra;
      irq_i = coinc;
      handler_done_i = 1'b1;
      t_done = cyc;
      tick;
      handler_done_i = 1'b0;
      irq_i = '0;
   endtask

   task automatic snap;
      for (int k = 0; k < 8; k++) saved[k] = rf[k];
   endtask

   task automatic episode;
      logic [NI-1:0] m, extra, coinc;
      logic [31:0] sp_start;
      int rounds;
      m = NI'($urandom_range(1, 255));
      for (int k = 0; k < 8; k++) rf[k] = $urandom;
      snap;
      sp_start = sp;
      pulse(m);
      quiet("R2 idle before save");
      tick;
      do_push(NI'(1) << $urandom_range(0, NI - 1), ($urandom_range(0, 1) == 1) ? $urandom_range(0, 7) : -1);
      do_vec(1'b0);
      rounds = 0;
      forever begin
         extra = '0;
         coinc = '0;
         if (rounds < 4 && $urandom_range(0, 2) == 0) extra = NI'($urandom_range(1, 255));
         if (rounds < 4 && pend_b == '0 && extra == '0 && $urandom_range(0, 3) == 0)
            coinc = NI'(1) << $urandom_range(0, NI - 1);
         handler($urandom_range(1, 4), extra, coinc);
         rounds++;
         if (pend_b != '0) begin
            do_vec(1'b1);
         end else begin
            do_pop;
            chk(sp == sp_start, "R5 sp restored", sp, sp_start);
            if (coinc == '0) break;
            pend_b |= coinc;
            tick;
            snap;
            do_push('0, -1);
            do_vec(1'b0);
         end
      end
      tick;
   endtask

   initial begin
      void'($urandom(32'h0005_eed1));
      sp = SP0;
      pend_b = '0;
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
      for (int n = 0; n < NI; n++) mem[(VT >> 2) + n] = vec_val(n);
      for (int k = 0; k < 8; k++) rf[k] = 32'hA000_0000 + 32'(k);

      tick;
      quiet("R1 quiet in reset");
      chk(!chain_o && !mem_we_o, "R1 flags in reset", {30'd0, chain_o, mem_we_o}, 32'd0);
      tick; tick;
      rst_n = 1'b1;
      tick;
      quiet("R1 quiet after reset");

      // R11: return pulse while idle does nothing
      handler_done_i = 1'b1;
      tick;
      handler_done_i = 1'b0;
      quiet("R11 done ignored");
      tick;
      quiet("R11 done ignored later");

      // single request, plain entry and exit
      snap;
      pulse(8'b0000_1000);
      quiet("R2 idle cycle");
      tick;
      do_push('0, -1);
      do_vec(1'b0);
      handler(2, '0, '0);
      do_pop;
      chk(sp == SP0, "R5 sp back", sp, SP0);
      tick;

      // three lines at once: lowest first, then chained twice
      for (int k = 0; k < 8; k++) rf[k] = 32'hB000_0000 + 32'(k);
      snap;
      pulse(8'b1010_0100);
      tick;
      do_push('0, -1);
      do_vec(1'b0);
      handler(3, '0, '0);
      do_vec(1'b1);
      chk(chain_gap == 1, "R9 chained gap", 32'(chain_gap), 32'd1);
      handler(1, '0, '0);
      do_vec(1'b1);
      handler(2, '0, '0);
      do_pop;
      chk(sp == SP0, "R6 sp after chains", sp, SP0);
      tick;

      // R4: lower line arrives mid-save, save unchanged, lower line vectored first
      snap;
      pulse(8'b0001_0000);
      tick;
      do_push(8'b0000_0010, 3);
      do_vec(1'b0);
      handler(1, '0, '0);
      do_vec(1'b1);
      handler(1, '0, '0);
      do_pop;
      tick;

      // R8: request on the same edge as the return goes the long way
      snap;
      pulse(8'b0000_0001);
      tick;
      do_push('0, -1);
      do_vec(1'b0);
      handler(2, '0, 8'b0100_0000);
      chk(!pc_load_o && reg_wr_o, "R8 no chain on same edge", {30'd0, pc_load_o, reg_wr_o}, 32'd1);
      do_pop;
      pend_b |= 8'b0100_0000;
      tick;
      snap;
      do_push('0, -1);
      full_gap = cyc - t_done;
      do_vec(1'b0);
      chk(full_gap == 18, "R9 full gap", 32'(full_gap), 32'd18);
      chk(full_gap - 1 >= 8, "R9 saving", 32'(full_gap - 1), 32'd8);
      handler(1, '0, '0);
      do_pop;
      tick;

      for (int e = 0; e < 40; e++) episode;

      quiet("R1 idle at end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule